// File: doc/BRIEF.md
# Decade Twisted-Ring Counter with One-Hot Decode

This block counts slow external events, modulo ten, inside a fast synchronous domain. A count pulse input and an inhibit input are sampled by the system clock. The count advances by one each time their combination, pulse high while inhibit low, goes from false to true. So a rising pulse edge counts while inhibit is low, and so does a falling inhibit edge while the pulse input is high. The state is held as a five-bit twisted-ring (Johnson) code. Ten one-hot outputs are decoded from adjacent ring-bit pairs, each with a two-input AND.

A carry output is high for the first five counts and low for the last five. Its rising edge therefore marks each wrap from nine back to zero, and it can drive the pulse input of a following stage. A synchronous-domain clear input forces the count to zero at once, whatever the pulse and inhibit inputs do. On release of the clear, the edge detector does not report a pulse level that was already high as a new edge. If the ring ever holds a code outside the ten-state cycle, the next count step sends it back to zero.

Top module: `decade_ring_counter`

## Requirements
- R1: While rst_ni is low, dec_o is 10'b00_0000_0001 (bit 0 high) and carry_o is 1.
- R2: A rising edge of cnt_i while inhibit_i is low advances the count by one.
- R3: A falling edge of inhibit_i while cnt_i is high advances the count by one.
- R4: While inhibit_i is high, edges of cnt_i leave the count unchanged.
- R5: A falling edge of cnt_i never changes the count, and neither does a rising edge of inhibit_i.
- R6: While clear_i is high, dec_o equals 10'b00_0000_0001, whatever cnt_i and inhibit_i do.
- R7: Releasing clear_i while cnt_i is high and inhibit_i is low produces no count.
- R8: Exactly one bit of dec_o is high. Bit k is high for count k, and successive counts step 0,1,...,9 and then back to 0.
- R9: carry_o is 1 for counts 0 to 4 and 0 for counts 5 to 9, so it rises on the step from 9 to 0.
- R10: An input change that causes a count first shows on dec_o just after the fourth rising clk_i edge that follows it, and not after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all inputs |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 1 | Count pulse input, asynchronous to clk_i |
| inhibit_i | input | 1 | Count inhibit, active high, asynchronous to clk_i |
| clear_i | input | 1 | Clear to count 0, active high, acts on the ring at once |
| dec_o | output | 10 | One-hot decoded count, bit k high for count k |
| carry_o | output | 1 | High for counts 0 to 4 |

## Verification
Four properties are checked on every cycle: dec_o is one-hot, carry_o agrees with the low half of dec_o, clear_i holds output 0, and any change of dec_o outside a clear is a single rotation by one place. Whether a given change on cnt_i and inhibit_i should count at all can only be shown by the bench. It drives every transition between the four input levels, on top of every count value, against an arithmetic mod-10 model. Clear release with the pulse input held high, and the exact four-edge latency, are covered only by directed scenarios.

// File: rtl/decade_pkg.sv
package decade_pkg;
  localparam int unsigned RING_W     = 5;
  localparam int unsigned NUM_OUT    = 2 * RING_W;
  localparam int unsigned SYNC_DEPTH = 2;
  typedef logic [RING_W-1:0]  ring_t;
  typedef logic [NUM_OUT-1:0] dec_t;
endpackage

// File: rtl/dr_sync.sv
module dr_sync #(
  parameter int unsigned WIDTH = 2,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [DEPTH-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/dr_edge.sv
module dr_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic cnt_s_i,
  input  logic inh_s_i,
  output logic step_o
);
  logic term, term_q, prev_q;

  assign term = cnt_s_i & ~inh_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      term_q <= 1'b0;
      prev_q <= 1'b0;
    end else if (clear_i) begin
      // re-prime: a level present during clear is not a new edge
      term_q <= term;
      prev_q <= term;
    end else begin
      term_q <= term;
      prev_q <= term_q;
    end
  end

  assign step_o = term_q & ~prev_q & ~clear_i;
endmodule

// File: rtl/dr_ring.sv
module dr_ring
  import decade_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clear_i,
  input  logic  step_i,
  output ring_t ring_o
);
  ring_t ring_q;

  function automatic logic is_legal(ring_t r);
    int unsigned n = 0;
    for (int i = 0; i < RING_W - 1; i++) n += 32'(r[i] ^ r[i+1]);
    return n <= 1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni or posedge clear_i) begin
    if (!rst_ni)      ring_q <= '0;
    else if (clear_i) ring_q <= '0;
    else if (step_i)  ring_q <= is_legal(ring_q) ? {ring_q[RING_W-2:0], ~ring_q[RING_W-1]}
                                                 : '0;
  end

  assign ring_o = ring_q;
endmodule

// File: rtl/dr_decode.sv
module dr_decode
  import decade_pkg::*;
(
  input  ring_t ring_i,
  output dec_t  dec_o,
  output logic  carry_o
);
  assign dec_o[0]      = ~ring_i[RING_W-1] & ~ring_i[0];
  assign dec_o[RING_W] =  ring_i[RING_W-1] &  ring_i[0];

  for (genvar k = 1; k < RING_W; k++) begin : g_dec
    assign dec_o[k]        =  ring_i[k-1] & ~ring_i[k];
    assign dec_o[RING_W+k] = ~ring_i[k-1] &  ring_i[k];
  end

  assign carry_o = ~ring_i[RING_W-1];
endmodule

// File: rtl/decade_ring_counter.sv
module decade_ring_counter
  import decade_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cnt_i,
  input  logic               inhibit_i,
  input  logic               clear_i,
  output logic [NUM_OUT-1:0] dec_o,
  output logic               carry_o
);
  logic [1:0] sync_q;
  logic       step;
  ring_t      ring;

  dr_sync #(.WIDTH(2), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({inhibit_i, cnt_i}),
    .q_o   (sync_q)
  );

  dr_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .cnt_s_i(sync_q[0]),
    .inh_s_i(sync_q[1]),
    .step_o (step)
  );

  dr_ring u_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .step_i (step),
    .ring_o (ring)
  );

  dr_decode u_dec (
    .ring_i (ring),
    .dec_o  (dec_o),
    .carry_o(carry_o)
  );
endmodule

// File: rtl/decade_ring_counter_chk.sv
module decade_ring_counter_chk
  import decade_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               clear_i,
  input logic [NUM_OUT-1:0] dec_o,
  input logic               carry_o
);
  logic [NUM_OUT-1:0] prev_dec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_dec_q <= NUM_OUT'(1);
    else         prev_dec_q <= dec_o;
  end

  assert_one_hot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(dec_o) == 1);

  assert_carry_half_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o == (|dec_o[RING_W-1:0]));

  assert_clear_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |-> dec_o == NUM_OUT'(1));

  assert_single_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_o != prev_dec_q) && !clear_i && !$past(clear_i)
      |-> dec_o == {prev_dec_q[NUM_OUT-2:0], prev_dec_q[NUM_OUT-1]});
endmodule

bind decade_ring_counter decade_ring_counter_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .clear_i(clear_i),
  .dec_o  (dec_o),
  .carry_o(carry_o)
);

// File: tb/decade_ring_counter_test.sv
`timescale 1ns/1ps
module decade_ring_counter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt = 1'b0;
  logic       inh = 1'b0;
  logic       clr = 1'b0;
  logic [9:0] dec;
  logic       carry;
  int         n_run = 0;
  int         n_fail = 0;
  int         model = 0;
  bit         cur_cp = 1'b0;
  bit         cur_ce = 1'b0;

  always #2.5 clk = ~clk;

  decade_ring_counter uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .cnt_i    (cnt),
    .inhibit_i(inh),
    .clear_i  (clr),
    .dec_o    (dec),
    .carry_o  (carry)
  );

  task automatic check(input string tag);
    logic [9:0] exp_dec = 10'(1) << model;
    logic       exp_c   = (model < 5);
    n_run++;
    if (dec !== exp_dec || carry !== exp_c) begin
      n_fail++;
      $display("FAIL %s: dec=%b carry=%b expected dec=%b carry=%b",
               tag, dec, carry, exp_dec, exp_c);
    end
  endtask

  // drive a level pair and update the arithmetic model
  task automatic drive(input bit cp, input bit ce);
    bit was = cur_cp & ~cur_ce;
    bit now = cp & ~ce;
    @(negedge clk);
    cnt = cp; inh = ce;
    cur_cp = cp; cur_ce = ce;
    if (!clr && !was && now) model = (model + 1) % 10;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: run hung, got no finish expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release");

    // every level-to-level transition on every count value
    for (int r = 0; r < 10; r++) begin
      for (int a = 0; a < 4; a++) begin
        for (int b = 0; b < 4; b++) begin
          bit acp = a[0], ace = a[1], bcp = b[0], bce = b[1];
          string tag;
          drive(acp, ace);
          if (!ace && !bce && !acp && bcp)               tag = "R2 cp rise";
          else if (acp && bcp && ace && !bce)            tag = "R3 ce fall";
          else if (ace && bce)                           tag = "R4 inhibited";
          else if ((acp && !bcp) || (!ace && bce))       tag = "R5 no-count edge";
          else                                           tag = "R8 sequence";
          drive(bcp, bce);
          check(tag);
          if (model == 0) check("R9 wrap carry");
        end
      end
    end

    // latency
    drive(1'b0, 1'b0);
    @(negedge clk);
    cnt = 1'b1; cur_cp = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 not yet after third edge");
    model = (model + 1) % 10;
    @(negedge clk);
    check("R10 after fourth edge");
    repeat (4) @(negedge clk);

    // clear with activity
    drive(1'b0, 1'b0);
    @(negedge clk);
    clr = 1'b1;
    model = 0;
    @(negedge clk);
    check("R6 clear applied");
    for (int i = 0; i < 4; i++) begin
      drive(1'b1, 1'b0);
      check("R6 clear held cp high");
      drive(1'b0, 1'b1);
      drive(1'b1, 1'b0);
      check("R6 clear held ce fall");
      drive(1'b0, 1'b0);
    end
    drive(1'b1, 1'b0);
    @(negedge clk);
    clr = 1'b0;
    repeat (8) @(negedge clk);
    check("R7 release no count");
    drive(1'b0, 1'b0);
    drive(1'b1, 1'b0);
    check("R2 count after clear");

    // full cycle carry and order
    for (int i = 0; i < 12; i++) begin
      drive(1'b0, 1'b0);
      drive(1'b1, 1'b0);
      check("R9 carry per count");
    end

    // reset mid-count
    @(negedge clk);
    rst_n = 1'b0;
    model = 0;
    @(negedge clk);
    check("R1 reset mid count");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule